// File: doc/BRIEF.md
# Dual-Channel Serial Result Register

This block is the output stage of a converter that measures two inputs in turn. Each conversion delivers a 20-bit parallel word with a done strobe and a select bit that says which input it belongs to. The word for the first input is parked in a holding register. When the word for the second input arrives, both are placed into a 40-bit shift register as one unit. A previous frame that nobody read is simply overwritten.

An active-low ready flag tells the reader that a frame is waiting. The reader pulls the active-low transmit enable low, which clears the flag and switches on the serial output. It then toggles the data clock. The register moves one bit toward the output on every falling data-clock edge, so the reader samples on the rising edge. The second input's word leaves first, most significant bit first, then the first input's word.

A serial input feeds the vacated tail position. Several blocks can therefore be chained into one long shift register. The data clock and transmit enable are sampled in the master-clock domain. The serial output is modelled as a data bit plus an enable bit; the data bit idles high while the output is disabled.

Top module: `dualResultSerializer`

## Requirements
- R1: During and right after reset the ready flag is high, the output enable is low and the serial data bit is high.
- R2: The first bit sampled after enabling transmission with the data clock low is bit 20 (MSB) of the second input's word. The remaining bits of that word follow in descending order.
- R3: A done strobe with the select bit at 1 loads the frame. If the ready flag was high and no pulse rule applies, the flag reads low from the next master-clock cycle.
- R4: A falling transition of transmit enable sets the ready flag high, and raises the output enable, in the next cycle.
- R5: The register shifts once per falling data-clock edge while transmission is enabled. The first input's word follows the second's, MSB to LSB, with no gap.
- R6: While transmit enable is high, data-clock edges leave the register unchanged, the output enable stays low and the data bit stays high.
- R7: Each shift takes the serial input into the tail position. After 40 shifts the bits that were shifted in leave in the order in which they entered.
- R8: If the data clock is high when transmit enable falls, its following falling edge shifts the MSB away. The first bit sampled is then bit 19 of the second input's word.
- R9: A load that arrives while the flag is low and transmit enable is high drives the ready flag high for exactly 12 master-clock cycles, after which it returns low.
- R10: A load always replaces the register contents, even when they were unread. If a load and a data-clock falling edge fall in the same cycle, the load wins and the shift is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resWord | input | 20 | Conversion result word |
| resDone | input | 1 | One-cycle strobe marking resWord as valid |
| resSel | input | 1 | 0 = first input's result, 1 = second input's result (triggers load) |
| dataClk | input | 1 | Serial data clock, sampled by clk |
| txEnN | input | 1 | Transmit enable, active low |
| serIn | input | 1 | Chain input shifted into the register tail |
| readyN | output | 1 | Frame-ready flag, active low |
| serOut | output | 1 | Serial data bit (high while disabled) |
| serOutEn | output | 1 | Output enable for serOut |

## Verification
The parallel load and a falling data-clock edge can land in the same master-clock cycle while transmission is enabled. The bench provokes this by holding the data clock high and then dropping it on the very cycle that carries the second result's done strobe. The shifted-out stream is then judged against a scoreboard expecting the new frame from its MSB with no bit missing, which shows that the load overrode the shift. The ready-flag update from a load colliding with a pending pulse is judged separately by counting its high cycles.

// File: rtl/resultSerPkg.sv
package resultSerPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdFirst;  // capture first input's word
    logic loadBoth;   // move held word and incoming word into shift register
    logic shiftOne;   // advance shift register by one bit
  } serStrobeT;

  // Ready-flag states
  typedef enum logic [1:0] {
    RDY_IDLE  = 2'd0,  // flag high, nothing waiting
    RDY_PEND  = 2'd1,  // flag low, frame waiting
    RDY_PULSE = 2'd2   // flag high for a fixed count, then waiting
  } readyStateT;

endpackage

// File: rtl/resultSerCtrl.sv
module resultSerCtrl
  import resultSerPkg::*;
#(
  parameter int PULSE_CYC = 12,
  localparam int CNT_W = $clog2(PULSE_CYC + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      resDone,
  input  logic      resSel,
  input  logic      dataClk,
  input  logic      txEnN,
  output serStrobeT strobes,
  output logic      readyN,
  output logic      outEn
);

  logic dclkPrev;
  logic txPrev;
  logic loadNow;
  logic dclkFall;
  logic txFall;
  readyStateT rdyState;
  logic [CNT_W-1:0] pulseCnt;

  // Sampled history of the serial-side controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dclkPrev <= 1'b0;
      txPrev   <= 1'b1;
      outEn    <= 1'b0;
    end else begin
      dclkPrev <= dataClk;
      txPrev   <= txEnN;
      outEn    <= ~txEnN;
    end
  end

  always_comb begin
    loadNow  = resDone & resSel;
    dclkFall = dclkPrev & ~dataClk & ~txEnN;
    txFall   = txPrev & ~txEnN;
    strobes.holdFirst = resDone & ~resSel;
    strobes.loadBoth  = loadNow;
    strobes.shiftOne  = dclkFall & ~loadNow;  // load has priority
  end

  // Ready flag sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyState <= RDY_IDLE;
      pulseCnt <= '0;
    end else if (loadNow) begin
      if (rdyState != RDY_IDLE && txEnN) begin
        rdyState <= RDY_PULSE;
        pulseCnt <= CNT_W'(PULSE_CYC - 1);
      end else begin
        rdyState <= RDY_PEND;
        pulseCnt <= '0;
      end
    end else if (txFall) begin
      rdyState <= RDY_IDLE;
      pulseCnt <= '0;
    end else if (rdyState == RDY_PULSE) begin
      if (pulseCnt == '0) begin
        rdyState <= RDY_PEND;
      end else begin
        pulseCnt <= pulseCnt - CNT_W'(1);
      end
    end
  end

  assign readyN = (rdyState != RDY_PEND);

endmodule

// File: rtl/resultSerDatapath.sv
module resultSerDatapath
  import resultSerPkg::*;
#(
  parameter int RES_W = 20,
  localparam int SR_W = 2 * RES_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  serStrobeT        strobes,
  input  logic [RES_W-1:0] resWord,
  input  logic             serIn,
  input  logic             outEn,
  output logic             serOut,
  output logic [SR_W-1:0]  srBits
);

  logic [RES_W-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobes.holdFirst) begin
      holdReg <= resWord;
    end
  end

  // Second input's word sits at the output end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srBits <= '0;
    end else if (strobes.loadBoth) begin
      srBits <= {resWord, holdReg};
    end else if (strobes.shiftOne) begin
      srBits <= {srBits[SR_W-2:0], serIn};
    end
  end

  assign serOut = outEn ? srBits[SR_W-1] : 1'b1;

endmodule

// File: rtl/dualResultSerializer.sv
module dualResultSerializer
  import resultSerPkg::*;
#(
  parameter int RES_W     = 20,
  parameter int PULSE_CYC = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] resWord,
  input  logic             resDone,
  input  logic             resSel,
  input  logic             dataClk,
  input  logic             txEnN,
  input  logic             serIn,
  output logic             readyN,
  output logic             serOut,
  output logic             serOutEn
);

  localparam int SR_W = 2 * RES_W;

  serStrobeT       strobes;
  logic [SR_W-1:0] shiftBits;

  resultSerCtrl #(.PULSE_CYC(PULSE_CYC)) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .resDone (resDone),
    .resSel  (resSel),
    .dataClk (dataClk),
    .txEnN   (txEnN),
    .strobes (strobes),
    .readyN  (readyN),
    .outEn   (serOutEn)
  );

  resultSerDatapath #(.RES_W(RES_W)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .resWord (resWord),
    .serIn   (serIn),
    .outEn   (serOutEn),
    .serOut  (serOut),
    .srBits  (shiftBits)
  );

endmodule

// File: rtl/resultSerChecker.sv
module resultSerChecker #(
  parameter int RES_W = 20,
  localparam int SR_W = 2 * RES_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [RES_W-1:0] resWord,
  input logic             resDone,
  input logic             resSel,
  input logic             dataClk,
  input logic             txEnN,
  input logic             serIn,
  input logic             readyN,
  input logic             serOut,
  input logic             serOutEn,
  input logic [SR_W-1:0]  srBits
);

  assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && resSel && readyN && !txEnN) |=> !readyN);

  assert_txfall_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txEnN) && !(resDone && resSel)) |=> (readyN && serOutEn));

  assert_shift_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnN && $past(dataClk) && !dataClk && !(resDone && resSel))
      |=> (srBits == {$past(srBits[SR_W-2:0]), $past(serIn)}));

  assert_idle_output_R6: assert property (@(posedge clk) disable iff (!rstN)
    txEnN |=> (!serOutEn && serOut));

  assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txEnN && !(resDone && resSel)) |=> $stable(srBits));

  assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && resSel && !readyN && txEnN) |=> readyN);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && resSel) |=> (srBits[SR_W-1:RES_W] == $past(resWord)));

endmodule

bind dualResultSerializer resultSerChecker #(.RES_W(RES_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .resWord  (resWord),
  .resDone  (resDone),
  .resSel   (resSel),
  .dataClk  (dataClk),
  .txEnN    (txEnN),
  .serIn    (serIn),
  .readyN   (readyN),
  .serOut   (serOut),
  .serOutEn (serOutEn),
  .srBits   (shiftBits)
);

// File: tb/dualResultSerializer_test.sv
`timescale 1ns/1ps
module dualResultSerializer_test;

  localparam int RES_W     = 20;
  localparam int PULSE_CYC = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [RES_W-1:0] resWord = '0;
  logic resDone = 1'b0;
  logic resSel = 1'b0;
  logic dataClk = 1'b0;
  logic txEnN = 1'b1;
  logic serIn = 1'b0;
  logic readyN;
  logic serOut;
  logic serOutEn;

  typedef struct {
    logic  v;
    string tag;
  } expT;
  expT expQ[$];

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dualResultSerializer #(.RES_W(RES_W), .PULSE_CYC(PULSE_CYC)) uut (
    .clk(clk), .rstN(rstN), .resWord(resWord), .resDone(resDone),
    .resSel(resSel), .dataClk(dataClk), .txEnN(txEnN), .serIn(serIn),
    .readyN(readyN), .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pushExp(logic [RES_W-1:0] w, int topBit, string tag);
    for (int i = topBit; i >= 0; i--) expQ.push_back('{w[i], tag});
  endtask

  task automatic giveResults(logic [RES_W-1:0] first, logic [RES_W-1:0] second);
    resSel = 1'b0; resWord = first; resDone = 1'b1;
    tick();
    resSel = 1'b1; resWord = second;
    tick();
    resDone = 1'b0;
  endtask

  // Per bit: raise (reader samples), then lower (shift at next clk edge)
  task automatic clockBits(int n, logic [63:0] pat);
    for (int i = 0; i < n; i++) begin
      dataClk = 1'b1;
      tick();
      dataClk = 1'b0;
      serIn = pat[n-1-i];
      tick();
    end
    serIn = 1'b0;
  endtask

  // Scoreboard monitor: compare on each reader sampling edge
  always @(posedge dataClk) begin
    if (!txEnN && expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      check(e.tag, {62'd0, serOutEn, serOut}, {62'd0, 1'b1, e.v});
    end
  end

  initial begin
    logic [39:0] pat;
    pat = 40'hC35A96F01E;
    repeat (3) tick();
    check("R1 ready", readyN, 1);
    check("R1 enable", serOutEn, 0);
    check("R1 data", serOut, 1);
    rstN = 1'b1;
    tick();
    check("R1 after release", {readyN, serOutEn, serOut}, 3'b101);

    // Load and idle clocking
    giveResults(20'h12345, 20'hABCDE);
    check("R3 ready low", readyN, 0);
    clockBits(3, 0);
    check("R6 enable low", serOutEn, 0);
    check("R6 data high", serOut, 1);

    txEnN = 1'b0;
    tick();
    check("R4 ready high", readyN, 1);
    check("R4 enable high", serOutEn, 1);
    pushExp(20'hABCDE, RES_W-1, "R2");
    pushExp(20'h12345, RES_W-1, "R5");
    for (int i = 39; i >= 0; i--) expQ.push_back('{pat[i], "R7"});
    clockBits(40, {24'd0, pat});
    clockBits(40, 0);
    check("R7 queue drained", expQ.size(), 0);
    txEnN = 1'b1;
    tick(); tick();

    // Data clock high at enable
    giveResults(20'h0F0F3, 20'h5A5A5);
    dataClk = 1'b1;
    tick();
    txEnN = 1'b0;
    tick(); tick();
    dataClk = 1'b0;
    tick(); tick();
    pushExp(20'h5A5A5, RES_W-2, "R8");
    pushExp(20'h0F0F3, RES_W-1, "R8");
    clockBits(39, 0);
    check("R8 queue drained", expQ.size(), 0);
    txEnN = 1'b1;
    tick(); tick();

    // Unread frame overwritten, pulse
    giveResults(20'h11111, 20'h22222);
    check("R3 ready low again", readyN, 0);
    tick(); tick();
    giveResults(20'h77777, 20'h80001);
    check("R9 pulse cycle 1", readyN, 1);
    for (int i = 2; i <= PULSE_CYC; i++) begin
      tick();
      check("R9 pulse high", readyN, 1);
    end
    tick();
    check("R9 pulse end", readyN, 0);
    txEnN = 1'b0;
    tick(); tick();
    pushExp(20'h80001, RES_W-1, "R10");
    pushExp(20'h77777, RES_W-1, "R10");
    clockBits(40, 0);
    check("R10 overwrite drained", expQ.size(), 0);

    // Load and shift in the same cycle
    resSel = 1'b0; resWord = 20'h3C3C3; resDone = 1'b1;
    tick();
    resDone = 1'b0;
    dataClk = 1'b1;
    tick(); tick();
    dataClk = 1'b0;
    resSel = 1'b1; resWord = 20'hE1E1E; resDone = 1'b1;
    tick();
    resDone = 1'b0;
    check("R10 ready low on collision", readyN, 0);
    tick();
    pushExp(20'hE1E1E, RES_W-1, "R10");
    pushExp(20'h3C3C3, RES_W-1, "R10");
    clockBits(40, 0);
    check("R10 collision drained", expQ.size(), 0);
    txEnN = 1'b1;
    tick(); tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule